// File: doc/BRIEF.md
# Two-Channel Serial Controller Register Port Decoder

This block sits between a byte-wide processor bus and the register file of a two-channel serial controller. Each channel shows the bus only two locations, a command location and a data location. The sixteen write registers and sixteen read registers of a channel are reached through a per-channel pointer. The first command write loads the pointer. The next command write, or any command read, uses the pointer and then returns it to register 0.

Data-location reads take one character from the receive queue of the addressed channel. Data-location writes hand one character to the transmitter of that channel. Channel A also owns a shared interrupt-pending byte. Other logic sets bits in it, and certain reads clear it. The decoder also accepts two legacy address forms: an alias pair at the top of each 16-byte window, and a word-shifted form where the byte travels in bits 15:8 of the bus word.

Top module: `serial_regport_dec`

## Requirements
- R1: After reset every write register is 0, the pending byte is 0, `irq_o` is low, read register 0 of channel A reads 8'h40, and read register 0 of channel B reads 0.
- R2: Address bits [4:3] select the channel and bits [2:0] select the location within it: 1 is the command location and 5 is the data location. A write to any other location changes nothing (pointer, registers, transmit), and a read from one returns 0.
- R3: A command write when no select is pending loads the pointer with bits [3:0] of the byte. The next command write on that channel stores its byte into the write register at that index. Register `k` of channel `c` appears on `wreg_o[(c*16+k)*8 +: 8]`.
- R4: After a command register write, or after any command read, the pointer of that channel is 0 and no select is pending.
- R5: Each channel has its own pointer and select state. Accesses to one channel leave the other channel's pending select intact.
- R6: Read registers 12 and 13 of a channel always return the contents of write registers 12 and 13 of the same channel.
- R7: Each set bit of `pend_set_i` is ORed into the pending byte, and `irq_o` is high while any pending bit is set. Through either channel, a command read of read register 3 clears the pending byte. Channel A returns the pending byte for this read and channel B returns 0.
- R8: A data-location read returns the channel's receive character and pulses that channel's `rx_pop_o` bit when `rx_valid_i` shows a character. Otherwise it returns 0 and pops nothing. Every data read clears the pending byte.
- R9: A data-location write raises `tx_valid_o` in the same cycle, with `tx_chan_o` set to the channel and `tx_data_o` set to the byte. `tx_valid_o` is low for every other access.
- R10: Address 0x0F acts as the channel A command location and address 0x1F acts as the channel A data location.
- R11: An access to location 0 or 4 is handled as an access to location 1 or 5 when its bus byte [7:0] is zero. Reads always count as zero. For writes the byte is taken from bits [15:8], and read data is returned in bits [15:8]. A write to location 0 or 4 with a non-zero low byte is ignored.
- R12: When a pending bit is set in the same cycle as a clearing read, the read returns the old byte and the new bit survives the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset within the block |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid in the access cycle |
| rx_valid_i | input | NCH | Receive character available, per channel |
| rx_data_i | input | NCH*8 | Receive character, per channel |
| rx_pop_o | output | NCH | Consume the receive character, per channel |
| tx_valid_o | output | 1 | Transmit character strobe |
| tx_chan_o | output | CH_W | Transmit channel |
| tx_data_o | output | 8 | Transmit character |
| pend_set_i | input | 8 | Pending bits to set |
| irq_o | output | 1 | Interrupt request |
| wreg_o | output | NCH*NREG*8 | Write register file contents |

## Verification
The pending byte is the point where two functions meet in one cycle. An outside set request and a clearing read (a command read of register 3, or a data read) can land on the same clock edge. The bench provokes this by driving `pend_set_i` during the RR3 read cycle. It judges the result three ways: the read must return the old byte, `irq_o` must still be high afterwards, and a second RR3 read must return exactly the newly set bit.

// File: rtl/serial_regport_pkg.sv
package serial_regport_pkg;
  typedef enum logic [1:0] {PK_NONE, PK_CMD, PK_DATA} port_kind_e;
  localparam int          BYTE_W      = 8;
  localparam logic [7:0]  RR0_A_INIT  = 8'h40;
  localparam int          IDX_PEND    = 3;
  localparam int          IDX_MIR_LO  = 12;
  localparam int          IDX_MIR_HI  = 13;
endpackage

// File: rtl/serial_regport_addr.sv
module serial_regport_addr
  import serial_regport_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int NCH    = 2,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output port_kind_e        kind_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [7:0]        val_o,
  output logic              shift_o
);
  localparam int CHR_W = ADDR_W - 3;

  logic [2:0]       rel;
  logic [CHR_W-1:0] chan_raw;
  logic [7:0]       lo_byte;
  logic             in_range;

  assign lo_byte = we_i ? wdata_i[7:0] : 8'h00;

  always_comb begin
    rel      = addr_i[2:0];
    chan_raw = addr_i[ADDR_W-1:3];
    // legacy alias at top of window
    if (addr_i[3:0] == 4'hF) begin
      chan_raw = '0;
      rel      = (addr_i == ADDR_W'(8'h0F)) ? 3'd1 : 3'd5;
    end
    shift_o = ((rel == 3'd0) || (rel == 3'd4)) && (lo_byte == 8'h00);
    if (shift_o) rel = rel | 3'd1;
    val_o    = shift_o ? wdata_i[15:8] : wdata_i[7:0];
    in_range = (int'(chan_raw) < NCH);
    chan_o   = chan_raw[CH_W-1:0];
    kind_o   = PK_NONE;
    if (req_i && in_range) begin
      if (rel == 3'd1)      kind_o = PK_CMD;
      else if (rel == 3'd5) kind_o = PK_DATA;
    end
  end
endmodule

// File: rtl/serial_regport_ptr.sv
module serial_regport_ptr #(
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] val_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic             armed_o,
  output logic             reg_we_o
);
  logic [IDX_W-1:0] ptr_q;
  logic             armed_q;

  assign reg_we_o = sel_i && we_i && armed_q;
  assign ptr_o    = ptr_q;
  assign armed_o  = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      armed_q <= 1'b0;
    end else if (sel_i) begin
      if (we_i && !armed_q) begin
        ptr_q   <= val_i;
        armed_q <= 1'b1;
      end else begin
        ptr_q   <= '0;
        armed_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_regport_regs.sv
module serial_regport_regs #(
  parameter int NCH    = 2,
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG),
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [CH_W-1:0]       wr_chan_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [7:0]            wr_val_i,
  input  logic [7:0]            pend_set_i,
  input  logic                  pend_clr_i,
  output logic [7:0]            pend_o,
  output logic [NCH*NREG*8-1:0] wreg_o
);
  logic [7:0] pend_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic [7:0] q;
      logic       hit;
      assign hit = wr_en_i && (int'(wr_chan_i) == c) && (int'(wr_idx_i) == r);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= 8'h00;
        else if (hit) q <= wr_val_i;
      end
      assign wreg_o[(c*NREG+r)*8 +: 8] = q;
    end
  end

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 8'h00;
    else         pend_q <= (pend_clr_i ? 8'h00 : pend_q) | pend_set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/serial_regport_dec.sv
module serial_regport_dec
  import serial_regport_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int NCH    = 2,
  parameter int NREG   = 16,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_req_i,
  input  logic                  bus_we_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  input  logic [NCH-1:0]        rx_valid_i,
  input  logic [NCH*8-1:0]      rx_data_i,
  output logic [NCH-1:0]        rx_pop_o,
  output logic                  tx_valid_o,
  output logic [CH_W-1:0]       tx_chan_o,
  output logic [7:0]            tx_data_o,
  input  logic [7:0]            pend_set_i,
  output logic                  irq_o,
  output logic [NCH*NREG*8-1:0] wreg_o
);
  localparam int IDX_W = $clog2(NREG);

  port_kind_e       dec_kind;
  logic [CH_W-1:0]  dec_chan;
  logic [7:0]       dec_val;
  logic             dec_shift;
  logic [IDX_W-1:0] ptr_q [NCH];
  logic [NCH-1:0]   armed_q;
  logic [NCH-1:0]   ch_we;
  logic [IDX_W-1:0] cur_ptr;
  logic             cmd_rd, data_rd, reg_we;
  logic [7:0]       pend;
  logic [7:0]       rr_byte, rd_byte;

  serial_regport_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH)) u_addr (
    .req_i   (bus_req_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .kind_o  (dec_kind),
    .chan_o  (dec_chan),
    .val_o   (dec_val),
    .shift_o (dec_shift)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ptr
    logic sel;
    assign sel = (dec_kind == PK_CMD) && (int'(dec_chan) == c);
    serial_regport_ptr #(.NREG(NREG)) u_ptr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sel_i    (sel),
      .we_i     (bus_we_i),
      .val_i    (dec_val[IDX_W-1:0]),
      .ptr_o    (ptr_q[c]),
      .armed_o  (armed_q[c]),
      .reg_we_o (ch_we[c])
    );
  end

  assign cur_ptr = ptr_q[dec_chan];
  assign reg_we  = |ch_we;
  assign cmd_rd  = (dec_kind == PK_CMD)  && !bus_we_i;
  assign data_rd = (dec_kind == PK_DATA) && !bus_we_i;

  serial_regport_regs #(.NCH(NCH), .NREG(NREG)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (reg_we),
    .wr_chan_i  (dec_chan),
    .wr_idx_i   (cur_ptr),
    .wr_val_i   (dec_val),
    .pend_set_i (pend_set_i),
    .pend_clr_i ((cmd_rd && (int'(cur_ptr) == IDX_PEND)) || data_rd),
    .pend_o     (pend),
    .wreg_o     (wreg_o)
  );

  always_comb begin
    rr_byte = 8'h00;
    if (int'(cur_ptr) == 0)               rr_byte = (dec_chan == '0) ? RR0_A_INIT : 8'h00;
    else if (int'(cur_ptr) == IDX_PEND)   rr_byte = (dec_chan == '0) ? pend : 8'h00;
    else if (int'(cur_ptr) == IDX_MIR_LO) rr_byte = wreg_o[(int'(dec_chan)*NREG+IDX_MIR_LO)*8 +: 8];
    else if (int'(cur_ptr) == IDX_MIR_HI) rr_byte = wreg_o[(int'(dec_chan)*NREG+IDX_MIR_HI)*8 +: 8];
  end

  always_comb begin
    rd_byte = 8'h00;
    if (cmd_rd) rd_byte = rr_byte;
    else if (data_rd && rx_valid_i[dec_chan]) rd_byte = rx_data_i[int'(dec_chan)*8 +: 8];
    bus_rdata_o = dec_shift ? (DATA_W'(rd_byte) << 8) : DATA_W'(rd_byte);
  end

  always_comb begin
    rx_pop_o = '0;
    if (data_rd) rx_pop_o[dec_chan] = rx_valid_i[dec_chan];
  end

  assign tx_valid_o = (dec_kind == PK_DATA) && bus_we_i;
  assign tx_chan_o  = dec_chan;
  assign tx_data_o  = dec_val;
  assign irq_o      = |pend;
endmodule

// File: rtl/serial_regport_chk.sv
module serial_regport_chk
  import serial_regport_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int NREG  = 16,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input port_kind_e            kind_i,
  input logic [CH_W-1:0]       chan_i,
  input logic [NCH-1:0]        armed_i,
  input logic [7:0]            pend_set_i,
  input logic                  irq_i,
  input logic                  tx_valid_i,
  input logic [NCH-1:0]        rx_pop_i,
  input logic [NCH*NREG*8-1:0] wreg_i
);
  logic [NCH-1:0] chan_oh;
  assign chan_oh = NCH'(1) << chan_i;

  p_tx_needs_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |-> (req_i && we_i));

  p_pop_needs_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rx_pop_i) |-> (req_i && !we_i && $onehot0(rx_pop_i)));

  p_set_raises_irq_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pend_set_i) |=> irq_i);

  p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !(req_i && !we_i)) |=> irq_i);

  p_wreg_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(wreg_i));

  p_disarm_after_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == PK_CMD && !we_i) |=> (armed_i == ($past(armed_i) & ~$past(chan_oh))));
endmodule

bind serial_regport_dec serial_regport_chk #(.NCH(NCH), .NREG(NREG)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (bus_req_i),
  .we_i       (bus_we_i),
  .kind_i     (dec_kind),
  .chan_i     (dec_chan),
  .armed_i    (armed_q),
  .pend_set_i (pend_set_i),
  .irq_i      (irq_o),
  .tx_valid_i (tx_valid_o),
  .rx_pop_i   (rx_pop_o),
  .wreg_i     (wreg_o)
);

// File: tb/serial_regport_dec_test.sv
module serial_regport_dec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  rx_valid = '0;
  logic [15:0] rx_data = '0;
  logic [1:0]  rx_pop;
  logic        tx_valid;
  logic [0:0]  tx_chan;
  logic [7:0]  tx_data;
  logic [7:0]  pend_set = '0;
  logic        irq;
  logic [255:0] wreg;

  int checks = 0, errors = 0;
  logic [15:0] rd_s;
  logic [1:0]  pop_s;
  logic        txv_s;
  logic [0:0]  txc_s;
  logic [7:0]  txd_s;

  always #2 clk = ~clk;

  serial_regport_dec uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_pop_o(rx_pop),
    .tx_valid_o(tx_valid), .tx_chan_o(tx_chan), .tx_data_o(tx_data),
    .pend_set_i(pend_set), .irq_o(irq), .wreg_o(wreg)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [4:0] a, input logic [15:0] d, input logic [7:0] ps);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; pend_set = ps;
    #1;
    rd_s = rdata; pop_s = rx_pop; txv_s = tx_valid; txc_s = tx_chan; txd_s = tx_data;
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0; pend_set = '0;
  endtask

  task automatic pend(input logic [7:0] ps);
    @(negedge clk);
    pend_set = ps;
    @(posedge clk);
    #1 pend_set = '0;
  endtask

  // {we, addr, wdata, expected read, tag}
  localparam int NV = 29;
  localparam logic [41:0] VEC [NV] = '{
    {1'b1, 5'h01, 16'h000C, 16'h0000, 4'd3},  // R3 select WR12 A
    {1'b1, 5'h01, 16'h005A, 16'h0000, 4'd3},  // R3 store
    {1'b1, 5'h01, 16'h000C, 16'h0000, 4'd6},
    {1'b0, 5'h01, 16'h0000, 16'h005A, 4'd6},  // R6 mirror
    {1'b0, 5'h01, 16'h0000, 16'h0040, 4'd4},  // R4 ptr back to 0
    {1'b1, 5'h09, 16'h000D, 16'h0000, 4'd5},
    {1'b1, 5'h09, 16'h0033, 16'h0000, 4'd5},
    {1'b1, 5'h09, 16'h000D, 16'h0000, 4'd6},
    {1'b0, 5'h09, 16'h0000, 16'h0033, 4'd5},  // R5 channel B
    {1'b1, 5'h0F, 16'h000D, 16'h0000, 4'd10}, // R10 alias cmd
    {1'b1, 5'h0F, 16'h0077, 16'h0000, 4'd10},
    {1'b1, 5'h01, 16'h000D, 16'h0000, 4'd10},
    {1'b0, 5'h01, 16'h0000, 16'h0077, 4'd10},
    {1'b1, 5'h00, 16'h0C00, 16'h0000, 4'd11}, // R11 shifted select
    {1'b0, 5'h00, 16'h0000, 16'h5A00, 4'd11},
    {1'b1, 5'h02, 16'h000C, 16'h0000, 4'd2},  // R2 ignored write
    {1'b0, 5'h01, 16'h0000, 16'h0040, 4'd2},
    {1'b0, 5'h02, 16'h0000, 16'h0000, 4'd2},
    {1'b1, 5'h00, 16'h0C01, 16'h0000, 4'd11}, // R11 nonzero low byte ignored
    {1'b0, 5'h01, 16'h0000, 16'h0040, 4'd11},
    {1'b1, 5'h01, 16'h00FC, 16'h0000, 4'd3},  // R3 low 4 bits only
    {1'b0, 5'h03, 16'h0000, 16'h0000, 4'd2},
    {1'b0, 5'h01, 16'h0000, 16'h005A, 4'd3},
    {1'b1, 5'h01, 16'h0001, 16'h0000, 4'd5},  // select WR1 A
    {1'b0, 5'h09, 16'h0000, 16'h0000, 4'd5},  // B access keeps A armed
    {1'b1, 5'h01, 16'h00AB, 16'h0000, 4'd5},
    {1'b1, 5'h01, 16'h0001, 16'h0000, 4'd4},
    {1'b0, 5'h01, 16'h0000, 16'h0000, 4'd4},
    {1'b0, 5'h01, 16'h0000, 16'h0040, 4'd4}
  };

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 wreg", 32'(wreg == '0), 32'd1);
    chk("R1 irq", 32'(irq), 32'd0);
    acc(1'b0, 5'h01, 16'h0, 8'h0); chk("R1 rr0 A", 32'(rd_s), 32'h40);
    acc(1'b0, 5'h09, 16'h0, 8'h0); chk("R1 rr0 B", 32'(rd_s), 32'h0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][41], VEC[i][40:36], VEC[i][35:20], 8'h00);
      if (!VEC[i][41]) chk($sformatf("R%0d vec %0d", VEC[i][3:0], i), 32'(rd_s), 32'(VEC[i][19:4]));
    end
    chk("R3 wr12A", 32'(wreg[96 +: 8]), 32'h5A);
    chk("R3 wr1A", 32'(wreg[8 +: 8]), 32'hAB);
    chk("R10 wr13A", 32'(wreg[104 +: 8]), 32'h77);
    chk("R5 wr13B", 32'(wreg[232 +: 8]), 32'h33);
    chk("R2 wr2A", 32'(wreg[16 +: 8]), 32'h00);

    // R7 pending set and clear
    pend(8'h20);
    chk("R7 irq set", 32'(irq), 32'd1);
    acc(1'b1, 5'h01, 16'h0003, 8'h0);
    acc(1'b0, 5'h01, 16'h0, 8'h0); chk("R7 rr3 A", 32'(rd_s), 32'h20);
    chk("R7 irq clr", 32'(irq), 32'd0);
    pend(8'h08);
    acc(1'b1, 5'h09, 16'h0003, 8'h0);
    acc(1'b0, 5'h09, 16'h0, 8'h0); chk("R7 rr3 B", 32'(rd_s), 32'h00);
    chk("R7 irq clr B", 32'(irq), 32'd0);

    // R12 set and clear in one cycle
    pend(8'h10);
    acc(1'b1, 5'h01, 16'h0003, 8'h0);
    acc(1'b0, 5'h01, 16'h0, 8'h04); chk("R12 old value", 32'(rd_s), 32'h10);
    chk("R12 irq kept", 32'(irq), 32'd1);
    acc(1'b1, 5'h01, 16'h0003, 8'h0);
    acc(1'b0, 5'h01, 16'h0, 8'h0); chk("R12 new bit", 32'(rd_s), 32'h04);

    // R8 receive path
    pend(8'h01);
    rx_valid = 2'b01; rx_data = 16'h66A5;
    acc(1'b0, 5'h05, 16'h0, 8'h0);
    chk("R8 data", 32'(rd_s), 32'hA5);
    chk("R8 pop", 32'(pop_s), 32'h1);
    chk("R8 irq clr", 32'(irq), 32'd0);
    acc(1'b0, 5'h0D, 16'h0, 8'h0);
    chk("R8 empty data", 32'(rd_s), 32'h0);
    chk("R8 empty pop", 32'(pop_s), 32'h0);
    acc(1'b0, 5'h04, 16'h0, 8'h0);
    chk("R11 shifted data read", 32'(rd_s), 32'hA500);
    rx_valid = 2'b00;

    // R9 transmit path
    acc(1'b1, 5'h0D, 16'h003C, 8'h0);
    chk("R9 tx valid", 32'(txv_s), 32'd1);
    chk("R9 tx chan", 32'(txc_s), 32'd1);
    chk("R9 tx data", 32'(txd_s), 32'h3C);
    acc(1'b1, 5'h1F, 16'h0099, 8'h0);
    chk("R10 alias tx chan", 32'(txc_s), 32'd0);
    chk("R10 alias tx data", 32'(txd_s), 32'h99);
    acc(1'b1, 5'h04, 16'h4200, 8'h0);
    chk("R11 shifted tx data", 32'(txd_s), 32'h42);
    acc(1'b1, 5'h01, 16'h0005, 8'h0);
    chk("R9 no tx on cmd", 32'(txv_s), 32'd0);
    acc(1'b1, 5'h01, 16'h0011, 8'h0);
    chk("R3 wr5A", 32'(wreg[40 +: 8]), 32'h11);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule